// File: doc/BRIEF.md
# Priority Interrupt Request Latch

This block collects three interrupt request pulses into a pending-request cell and holds them until each is serviced. Sources are numbered 3, 4 and 5; source 5 carries keyboard data. A global inhibit input hides the pending condition from the processor without discarding requests, so nothing raised during an inhibited window is lost.

When the processor issues its address-read control pulse, the block picks the highest-priority pending source. Source 3 has the highest priority and source 5 the lowest. The block loads the jump-table address of that source into its vector output and clears that source's pending bit, all on the same clock edge. Each jump-table entry is a fixed number of words wide, so the vector is a base address plus the stride times the source's offset from source 3. Saving processor context and running the service routine are left to the surrounding logic.

Top module: `irq_vector_latch`

## Requirements
- R1: After reset no request is pending, `irq_pend_o` is 0 and `vec_addr_o` equals `VEC_BASE`.
- R2: A one-cycle high on `req_i[k]` (bit 0 = source 3, bit 1 = source 4, bit 2 = source 5 keyboard) sampled at a rising edge makes `irq_pend_o` high after that edge. The request stays pending until it is serviced.
- R3: While `inhibit_i` is high, `irq_pend_o` is 0 but requests are still latched. When the inhibit drops, `irq_pend_o` goes high if anything is pending.
- R4: Priority is fixed: `req_i` bit 0 (source 3) over bit 1 (source 4) over bit 2 (source 5).
- R5: `vec_addr_o` is registered. At an edge where `rd_addr_i` is high, `inhibit_i` is low and a request is pending, it loads `VEC_BASE + VEC_STRIDE*k`, where k is the bit index of the winning source. At all other edges it holds.
- R6: The winning source's pending bit clears on that same edge. The other pending bits are kept.
- R7: A request that arrives on the same edge as a service is latched, even when it is for the source being cleared.
- R8: An `rd_addr_i` pulse with nothing pending, or while `inhibit_i` is high, changes neither the vector nor any pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Request pulses; bit 0 = source 3, bit 2 = keyboard source 5 |
| inhibit_i | input | 1 | Global interrupt inhibit |
| rd_addr_i | input | 1 | Address-read control pulse |
| irq_pend_o | output | 1 | A serviceable request exists |
| vec_addr_o | output | ADDR_W | Jump-table address of the last serviced source |

## Verification
The bench builds the block with its three sources, a 12-bit address, a stride of 4 and `VEC_BASE` set to 0xFF0. With that base the vectors 0xFF0, 0xFF4 and 0xFF8 sit near the top of the address space, so a wrong offset width or a truncated addition shows up. The directed scenarios service all three sources raised together, so that priority and the retained bits can be seen in order through repeated reads. They also raise a request on the very edge that clears it, and they issue reads while inhibited and while nothing is pending.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_NSRC_DEF   = 3;
  localparam int unsigned IRQ_ADDR_W_DEF = 12;
  localparam int unsigned IRQ_STRIDE_DEF = 4;
  localparam int unsigned IRQ_FIRST_ID   = 3;  // lowest source number, maps to bit 0
endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell #(
  parameter int unsigned NUM_SRC = irq_pkg::IRQ_NSRC_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // set wins over clear so a same-edge request survives
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[i] <= 1'b0;
      else         pend_q[i] <= set_i[i] | (pend_q[i] & ~clr_i[i]);
    end

    assert_set_only_by_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[i]) |-> $past(set_i[i]));
    assert_clear_only_by_service_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_q[i]) |-> $past(clr_i[i]));
    assert_same_edge_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_q[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned NUM_SRC = irq_pkg::IRQ_NSRC_DEF,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  logic [NUM_SRC:0] lower_busy;

  assign lower_busy[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign grant_o[i]      = pend_i[i] & ~lower_busy[i];
    assign lower_busy[i+1] = lower_busy[i] | pend_i[i];
  end
  assign any_o = lower_busy[NUM_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pend_i[i]) idx_o = IDX_W'(i);
  end

  always_comb begin
    assert_grant_onehot_R4: assert ($onehot0(grant_o));
    assert_grant_is_pending_R4: assert ((grant_o & ~pend_i) == '0);
  end
endmodule

// File: rtl/irq_vec_reg.sv
module irq_vec_reg #(
  parameter int unsigned  ADDR_W   = irq_pkg::IRQ_ADDR_W_DEF,
  parameter int unsigned  IDX_W    = 2,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  parameter int unsigned  VEC_STRIDE = irq_pkg::IRQ_STRIDE_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] vec_o
);
  logic [ADDR_W-1:0] vec_q;
  logic [ADDR_W-1:0] vec_d;

  assign vec_d = VEC_BASE + ADDR_W'(VEC_STRIDE) * ADDR_W'(idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vec_q <= VEC_BASE;
    else if (load_i) vec_q <= vec_d;
  end

  assert_vec_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(vec_q));

  assign vec_o = vec_q;
endmodule

// File: rtl/irq_vector_latch.sv
module irq_vector_latch #(
  parameter int unsigned NUM_SRC    = irq_pkg::IRQ_NSRC_DEF,
  parameter int unsigned ADDR_W     = irq_pkg::IRQ_ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] VEC_BASE = ADDR_W'(12'h040),
  parameter int unsigned VEC_STRIDE = irq_pkg::IRQ_STRIDE_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic              inhibit_i,
  input  logic              rd_addr_i,
  output logic              irq_pend_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] clr;
  logic [IDX_W-1:0]   idx;
  logic               any;
  logic               take;

  irq_pend_cell #(.NUM_SRC(NUM_SRC)) u_cell (
    .clk_i (clk_i), .rst_ni(rst_ni), .set_i(req_i), .clr_i(clr), .pend_o(pend)
  );

  irq_prio_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .pend_i(pend), .grant_o(grant), .idx_o(idx), .any_o(any)
  );

  assign take = rd_addr_i & ~inhibit_i & any;
  assign clr  = take ? grant : '0;

  irq_vec_reg #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_vec (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(take), .idx_i(idx), .vec_o(vec_addr_o)
  );

  assign irq_pend_o = any & ~inhibit_i;

  assert_no_service_when_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i && (inhibit_i || pend == '0) && req_i == '0) |=> (pend == $past(pend)));
  assert_inhibit_keeps_requests_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_i && req_i != '0) |=> (pend != '0));
endmodule

// File: tb/irq_vector_latch_test.sv
module irq_vector_latch_test;
  localparam logic [11:0] BASE = 12'hFF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] req = '0;
  logic inh = 1'b0;
  logic rd = 1'b0;
  logic pend_o;
  logic [11:0] vec_o;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  irq_vector_latch #(.NUM_SRC(3), .ADDR_W(12), .VEC_BASE(BASE), .VEC_STRIDE(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .inhibit_i(inh), .rd_addr_i(rd),
    .irq_pend_o(pend_o), .vec_addr_o(vec_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive for one edge, then sample at the following falling edge
  task automatic step(input logic [2:0] r, input logic a);
    req = r; rd = a;
    @(negedge clk);
    req = '0; rd = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pend after reset", int'(pend_o), 0);
    chk("R1 vec after reset", int'(vec_o), int'(BASE));
  endtask

  task automatic t_single;
    step(3'b100, 1'b0);
    chk("R2 keyboard req latched", int'(pend_o), 1);
    step(3'b000, 1'b0);
    chk("R2 req held", int'(pend_o), 1);
    step(3'b000, 1'b1);
    chk("R5 keyboard vector", int'(vec_o), int'(BASE + 12'd8));
    chk("R6 cleared after service", int'(pend_o), 0);
  endtask

  task automatic t_priority;
    step(3'b111, 1'b0);
    step(3'b000, 1'b1);
    chk("R4 source3 first", int'(vec_o), int'(BASE));
    chk("R6 others kept", int'(pend_o), 1);
    step(3'b000, 1'b1);
    chk("R4 source4 second", int'(vec_o), int'(BASE + 12'd4));
    step(3'b000, 1'b1);
    chk("R4 source5 last", int'(vec_o), int'(BASE + 12'd8));
    chk("R6 all serviced", int'(pend_o), 0);
  endtask

  task automatic t_inhibit;
    inh = 1'b1;
    step(3'b010, 1'b0);
    chk("R3 pend masked", int'(pend_o), 0);
    step(3'b000, 1'b1);
    chk("R8 no vector while inhibited", int'(vec_o), int'(BASE + 12'd8));
    inh = 1'b0;
    #1;
    chk("R3 request kept through inhibit", int'(pend_o), 1);
    step(3'b000, 1'b1);
    chk("R5 source4 vector", int'(vec_o), int'(BASE + 12'd4));
    chk("R6 cleared", int'(pend_o), 0);
  endtask

  task automatic t_empty;
    step(3'b000, 1'b1);
    chk("R8 empty read vec held", int'(vec_o), int'(BASE + 12'd4));
    chk("R8 empty read no pend", int'(pend_o), 0);
  endtask

  task automatic t_same_edge;
    step(3'b001, 1'b0);
    step(3'b001, 1'b1);
    chk("R7 serviced source3", int'(vec_o), int'(BASE));
    chk("R7 same-source req kept", int'(pend_o), 1);
    step(3'b000, 1'b1);
    chk("R7 second service", int'(vec_o), int'(BASE));
    chk("R7 empty after", int'(pend_o), 0);
    step(3'b010, 1'b0);
    step(3'b001, 1'b1);
    chk("R7 old winner serviced", int'(vec_o), int'(BASE + 12'd4));
    step(3'b000, 1'b1);
    chk("R7 new source3 kept", int'(vec_o), int'(BASE));
    chk("R6 drained", int'(pend_o), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_priority();
        t_inhibit();
        t_empty();
        t_same_edge();
      end
      begin
        repeat (2000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule